// File: doc/BRIEF.md
# Incremental Data Pointer Sequencer

This block keeps a data pointer next to the program counter and services instructions whose immediate lives in a separate, pointer-addressed constant stream rather than in the instruction word. For each such instruction it decodes a 12-bit pointer field, reads the immediate from the data port at the correct address with the correct byte length, returns the zero-extended immediate with a one-cycle done pulse, and at the same edge commits the next program counter and the next pointer value.

The field can open a new block of constants that sits right after the instruction. In that case the pointer moves to the first word of that block and the program counter skips over it. Otherwise the immediate is read at the current pointer. After the read, the pointer either steps forward by the immediate size or makes a signed jump of whole 4-byte words. A direct write port loads the pointer so that software can set it, or save and restore it around interrupts. A write always wins over an update from an instruction.

Top module: `dp_seq`

## Requirements
- R1: After reset the pointer reads zero, `ins_ready_o` is high, and neither `rd_req_valid_o` nor `done_o` is asserted.
- R2: The field is decoded as block length in bits 11:8 (unsigned), size code in bits 7:6 and jump in bits 5:0 (two's complement).
- R3: With a nonzero block length B, the read address is `ins_pc_i + 4` and the committed next PC is `ins_pc_i + 4 + 4*B`.
- R4: With a block length of zero, the read address is the pointer value at acceptance and the committed next PC is `ins_pc_i + 4`.
- R5: Size code k requests `rd_len_o = 2^k` bytes (1, 2, 4, 8), and `imm_o` holds the low 8*2^k bits of the response data with all bits above them zero.
- R6: When the jump is zero, the new pointer is the read address plus the byte length.
- R7: When the jump J is nonzero, the new pointer is the read address plus 4*J, with J signed. The byte length is not added.
- R8: The request holds `rd_req_valid_o` with a stable address until `rd_req_ready_i`. `done_o`, `imm_o`, `npc_o` and the pointer update appear in the cycle after `rd_resp_valid_i` and not before. `done_o` lasts exactly one cycle.
- R9: When `dp_wr_en_i` is high, `dp_o` equals `dp_wr_data_i` in the next cycle. This holds even if an instruction commits at the same edge.
- R10: While an instruction is in flight, `ins_ready_o` is low and `ins_valid_i` is ignored. No second request is issued for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid_i | input | 1 | Instruction with pointer field presented |
| ins_ready_o | output | 1 | Sequencer idle and able to accept |
| ins_field_i | input | 12 | Pointer-style immediate field |
| ins_pc_i | input | AW | PC of the presented instruction |
| rd_req_valid_o | output | 1 | Data read request valid |
| rd_req_ready_i | input | 1 | Data port accepts request |
| rd_addr_o | output | AW | Byte address of the read |
| rd_len_o | output | 4 | Read length in bytes |
| rd_resp_valid_i | input | 1 | Read data returned |
| rd_resp_data_i | input | DW | Read data, byte 0 in bits 7:0 |
| done_o | output | 1 | One-cycle pulse: immediate and next PC valid |
| imm_o | output | DW | Zero-extended immediate |
| npc_o | output | AW | Next PC committed with the immediate |
| dp_o | output | AW | Current data pointer |
| dp_wr_en_i | input | 1 | Load pointer from software |
| dp_wr_data_i | input | AW | Value loaded into the pointer |

## Verification
A wrong pointer shows up at `rd_addr_o` on the next instruction that uses a zero block length. It is also visible on `dp_o` in the cycle right after the commit, so the bench compares the pointer against its model on every clock. A wrong decode of the size code shows up at once on `rd_len_o` and later in the masked `imm_o`. A wrong handshake state shows up as a request whose address moves, a done pulse without a response, or a second request for an instruction that arrived while the block was busy. The bench catches each of these within one or two cycles of its cause.

// File: rtl/dp_seq_pkg.sv
package dp_seq_pkg;

    localparam int FIELD_W = 12;
    localparam int LEN_W   = 4;

    // Packed order matches the field bit positions: 11:8, 7:6, 5:0
    typedef struct packed {
        logic [3:0]        blk;
        logic [1:0]        szc;
        logic signed [5:0] jmp;
    } dp_field_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } dp_state_t;

    function automatic logic [LEN_W-1:0] size_bytes(input logic [1:0] szc);
        return LEN_W'(1) << szc;
    endfunction

endpackage

// File: rtl/dp_addr_gen.sv
module dp_addr_gen
    import dp_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  dp_field_t        fld,
    input  logic [AW-1:0]    pc,
    input  logic [AW-1:0]    dp_cur,
    output logic [AW-1:0]    rd_base,
    output logic [LEN_W-1:0] rd_len,
    output logic [AW-1:0]    nxt_dp,
    output logic [AW-1:0]    nxt_pc
);
    logic [AW-1:0] step;
    logic [AW-1:0] jmp_words;

    always_comb begin
        rd_len    = size_bytes(fld.szc);
        jmp_words = {{(AW-6){fld.jmp[5]}}, fld.jmp} << 2;
        rd_base   = (fld.blk != 4'd0) ? pc + AW'(4) : dp_cur;
        step      = (fld.jmp != 6'sd0) ? jmp_words : AW'(rd_len);
        nxt_dp    = rd_base + step;
        nxt_pc    = pc + AW'(4) + AW'({fld.blk, 2'b00});
    end
endmodule

// File: rtl/dp_imm_mask.sv
module dp_imm_mask
    import dp_seq_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [1:0]    szc,
    input  logic [DW-1:0] raw,
    output logic [DW-1:0] imm
);
    localparam int LANES = DW / 8;

    logic [LEN_W-1:0] nbytes;
    assign nbytes = size_bytes(szc);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < 8) begin : g_live
            assign imm[8*i +: 8] = (nbytes > LEN_W'(i)) ? raw[8*i +: 8] : 8'h00;
        end else begin : g_dead
            assign imm[8*i +: 8] = 8'h00;
        end
    end
endmodule

// File: rtl/dp_rd_fsm.sv
module dp_rd_fsm
    import dp_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ins_valid,
    input  logic req_ready,
    input  logic resp_valid,
    output logic idle,
    output logic req_valid,
    output logic accept,
    output logic finish
);
    dp_state_t st_q;

    assign idle      = (st_q == ST_IDLE);
    assign req_valid = (st_q == ST_REQ);
    assign accept    = idle && ins_valid;
    assign finish    = (st_q == ST_WAIT) && resp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (ins_valid)  st_q <= ST_REQ;
                ST_REQ:  if (req_ready)  st_q <= ST_WAIT;
                ST_WAIT: if (resp_valid) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dp_seq.sv
module dp_seq
    import dp_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ins_valid_i,
    output logic                 ins_ready_o,
    input  logic [FIELD_W-1:0]   ins_field_i,
    input  logic [AW-1:0]        ins_pc_i,
    output logic                 rd_req_valid_o,
    input  logic                 rd_req_ready_i,
    output logic [AW-1:0]        rd_addr_o,
    output logic [LEN_W-1:0]     rd_len_o,
    input  logic                 rd_resp_valid_i,
    input  logic [DW-1:0]        rd_resp_data_i,
    output logic                 done_o,
    output logic [DW-1:0]        imm_o,
    output logic [AW-1:0]        npc_o,
    output logic [AW-1:0]        dp_o,
    input  logic                 dp_wr_en_i,
    input  logic [AW-1:0]        dp_wr_data_i
);
    typedef struct packed {
        logic [1:0]       szc;
        logic [AW-1:0]    base;
        logic [LEN_W-1:0] len;
        logic [AW-1:0]    nxt_dp;
        logic [AW-1:0]    nxt_pc;
    } pend_t;

    dp_field_t        fld;
    logic             accept, finish, idle;
    logic [AW-1:0]    g_base, g_nxt_dp, g_nxt_pc;
    logic [LEN_W-1:0] g_len;
    logic [DW-1:0]    masked;
    pend_t            pend_q;
    logic [AW-1:0]    dp_q, npc_q;
    logic [DW-1:0]    imm_q;
    logic             done_q;

    assign fld = dp_field_t'(ins_field_i);

    dp_rd_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ins_valid  (ins_valid_i),
        .req_ready  (rd_req_ready_i),
        .resp_valid (rd_resp_valid_i),
        .idle       (idle),
        .req_valid  (rd_req_valid_o),
        .accept     (accept),
        .finish     (finish)
    );

    dp_addr_gen #(.AW(AW)) u_agen (
        .fld     (fld),
        .pc      (ins_pc_i),
        .dp_cur  (dp_q),
        .rd_base (g_base),
        .rd_len  (g_len),
        .nxt_dp  (g_nxt_dp),
        .nxt_pc  (g_nxt_pc)
    );

    dp_imm_mask #(.DW(DW)) u_mask (
        .szc (pend_q.szc),
        .raw (rd_resp_data_i),
        .imm (masked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (accept) begin
            pend_q <= '{szc: fld.szc, base: g_base, len: g_len,
                        nxt_dp: g_nxt_dp, nxt_pc: g_nxt_pc};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q   <= '0;
            npc_q  <= '0;
            imm_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                imm_q <= masked;
                npc_q <= pend_q.nxt_pc;
            end
            if (dp_wr_en_i) begin
                dp_q <= dp_wr_data_i;
            end else if (finish) begin
                dp_q <= pend_q.nxt_dp;
            end
        end
    end

    assign ins_ready_o = idle;
    assign rd_addr_o   = pend_q.base;
    assign rd_len_o    = pend_q.len;
    assign done_o      = done_q;
    assign imm_o       = imm_q;
    assign npc_o       = npc_q;
    assign dp_o        = dp_q;
endmodule

// File: rtl/dp_seq_chk.sv
module dp_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          ins_ready_o,
    input logic          rd_req_valid_o,
    input logic          rd_req_ready_i,
    input logic [AW-1:0] rd_addr_o,
    input logic [3:0]    rd_len_o,
    input logic          rd_resp_valid_i,
    input logic          done_o,
    input logic [AW-1:0] dp_o,
    input logic          dp_wr_en_i,
    input logic [AW-1:0] dp_wr_data_i
);
    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid_o && !rd_req_ready_i) |=> (rd_req_valid_o && $stable(rd_addr_o)));

    // R8
    done_after_resp_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(rd_resp_valid_i));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        dp_wr_en_i |=> (dp_o == $past(dp_wr_data_i)));

    // R10
    idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        ins_ready_o |-> !rd_req_valid_o);

    // R5
    len_pow2_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid_o |-> $onehot(rd_len_o) && (rd_len_o <= 4'd8));
endmodule

bind dp_seq dp_seq_chk #(.AW(AW)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .ins_ready_o     (ins_ready_o),
    .rd_req_valid_o  (rd_req_valid_o),
    .rd_req_ready_i  (rd_req_ready_i),
    .rd_addr_o       (rd_addr_o),
    .rd_len_o        (rd_len_o),
    .rd_resp_valid_i (rd_resp_valid_i),
    .done_o          (done_o),
    .dp_o            (dp_o),
    .dp_wr_en_i      (dp_wr_en_i),
    .dp_wr_data_i    (dp_wr_data_i)
);

// File: tb/dp_seq_tb.sv
module dp_seq_tb;
    localparam int AW = 32;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          ins_valid_i, ins_ready_o;
    logic [11:0]   ins_field_i;
    logic [AW-1:0] ins_pc_i;
    logic          rd_req_valid_o, rd_req_ready_i;
    logic [AW-1:0] rd_addr_o;
    logic [3:0]    rd_len_o;
    logic          rd_resp_valid_i;
    logic [DW-1:0] rd_resp_data_i;
    logic          done_o;
    logic [DW-1:0] imm_o;
    logic [AW-1:0] npc_o, dp_o;
    logic          dp_wr_en_i;
    logic [AW-1:0] dp_wr_data_i;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] exp_dp = '0;
    logic model_on = 1'b0;

    always #2 clk = ~clk;

    dp_seq #(.AW(AW), .DW(DW)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // pointer compared with the model on every clock (R6 R7 R9)
    always @(negedge clk) begin
        #1;
        if (model_on) chk(dp_o == exp_dp, "R6/R7/R9", "dp_o per clock", 64'(dp_o), 64'(exp_dp));
    end

    task automatic sw_write(input logic [AW-1:0] v);
        dp_wr_en_i = 1'b1; dp_wr_data_i = v;
        @(negedge clk);
        dp_wr_en_i = 1'b0;
        exp_dp = v;
        chk(dp_o == v, "R9", "pointer write", 64'(dp_o), 64'(v));
    endtask

    task automatic run_insn(input logic [3:0] blk, input logic [1:0] szc, input logic [5:0] jmp,
                            input logic [AW-1:0] pc, input logic [DW-1:0] data,
                            input int rdly, input int sdly,
                            input bit wr_at_resp, input logic [AW-1:0] wr_val, input bit poke);
        logic [AW-1:0] e_addr, e_npc, e_ndp;
        logic [3:0]    e_len;
        logic [DW-1:0] e_imm;
        e_addr = (blk != 0) ? pc + 4 : exp_dp;
        e_len  = 4'(1 << szc);
        e_ndp  = (jmp != 0) ? e_addr + AW'($signed(jmp) * 4) : e_addr + AW'(e_len);
        e_npc  = pc + 4 + AW'(blk) * 4;
        e_imm  = (szc == 2'd3) ? data : data & ((64'd1 << (8 * e_len)) - 1);

        chk(ins_ready_o == 1'b1, "R10", "ready before accept", 64'(ins_ready_o), 64'd1);
        ins_valid_i = 1'b1; ins_field_i = {blk, szc, jmp}; ins_pc_i = pc;
        @(negedge clk);
        ins_valid_i = 1'b0; ins_field_i = 12'hFFF; ins_pc_i = '1;
        chk(ins_ready_o == 1'b0, "R10", "busy after accept", 64'(ins_ready_o), 64'd0);
        chk(rd_req_valid_o == 1'b1, "R8", "request raised", 64'(rd_req_valid_o), 64'd1);
        chk(rd_addr_o == e_addr, (blk != 0) ? "R3" : "R4", "read address", 64'(rd_addr_o), 64'(e_addr));
        chk(rd_len_o == e_len, "R5", "read length", 64'(rd_len_o), 64'(e_len));
        for (int i = 0; i < rdly; i++) begin
            @(negedge clk);
            chk(rd_req_valid_o && rd_addr_o == e_addr, "R8", "request held",
                64'(rd_addr_o), 64'(e_addr));
        end
        rd_req_ready_i = 1'b1;
        @(negedge clk);
        rd_req_ready_i = 1'b0;
        chk(rd_req_valid_o == 1'b0, "R8", "request dropped", 64'(rd_req_valid_o), 64'd0);
        if (poke) begin
            ins_valid_i = 1'b1; ins_field_i = 12'h1C5; ins_pc_i = 32'h4000;
            @(negedge clk);
            ins_valid_i = 1'b0;
            chk(rd_req_valid_o == 1'b0 && done_o == 1'b0, "R10", "busy valid ignored",
                64'(rd_req_valid_o), 64'd0);
        end
        for (int i = 0; i < sdly; i++) begin
            @(negedge clk);
            chk(done_o == 1'b0, "R8", "no done before response", 64'(done_o), 64'd0);
        end
        rd_resp_valid_i = 1'b1; rd_resp_data_i = data;
        if (wr_at_resp) begin dp_wr_en_i = 1'b1; dp_wr_data_i = wr_val; end
        @(negedge clk);
        rd_resp_valid_i = 1'b0; rd_resp_data_i = '1; dp_wr_en_i = 1'b0;
        exp_dp = wr_at_resp ? wr_val : e_ndp;
        chk(done_o == 1'b1, "R8", "done pulse", 64'(done_o), 64'd1);
        chk(imm_o == e_imm, "R5", "immediate", imm_o, e_imm);
        chk(npc_o == e_npc, (blk != 0) ? "R3" : "R4", "next pc", 64'(npc_o), 64'(e_npc));
        chk(dp_o == exp_dp, wr_at_resp ? "R9" : ((jmp != 0) ? "R7" : "R6"), "new pointer",
            64'(dp_o), 64'(exp_dp));
        @(negedge clk);
        chk(done_o == 1'b0, "R8", "done one cycle", 64'(done_o), 64'd0);
        if (poke) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(rd_req_valid_o == 1'b0, "R10", "no request from ignored valid",
                    64'(rd_req_valid_o), 64'd0);
            end
        end
    endtask

    initial begin
        rst = 1'b1; ins_valid_i = 0; ins_field_i = '0; ins_pc_i = '0;
        rd_req_ready_i = 0; rd_resp_valid_i = 0; rd_resp_data_i = '0;
        dp_wr_en_i = 0; dp_wr_data_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(dp_o == '0, "R1", "reset pointer", 64'(dp_o), 64'd0);
        chk(ins_ready_o && !rd_req_valid_o && !done_o, "R1", "reset handshake",
            {61'd0, ins_ready_o, rd_req_valid_o, done_o}, 64'h4);
        model_on = 1'b1;
        // R2 R3 R5 R6: new block, 8 bytes, no jump
        run_insn(4'd2, 2'd3, 6'd0, 32'h100, 64'h8877665544332211, 0, 0, 0, '0, 0);
        // R4 R6: 16-bit, current pointer
        run_insn(4'd0, 2'd1, 6'd0, 32'h10C, 64'h8877665544332211, 1, 0, 0, '0, 0);
        // R7: backward jump of two words, 8-bit
        run_insn(4'd0, 2'd0, 6'h3E, 32'h110, 64'hFFFF_FFFF_FFFF_FFA5, 0, 1, 0, '0, 0);
        // R7 R8: forward jump with handshake delays, 32-bit
        run_insn(4'd0, 2'd2, 6'd3, 32'h114, 64'hDEAD_BEEF_CAFE_F00D, 3, 2, 0, '0, 0);
        // R3 R7: new block of 15 words plus jump
        run_insn(4'd15, 2'd2, 6'd1, 32'h200, 64'h0123_4567_89AB_CDEF, 0, 0, 0, '0, 0);
        // R9: software write then read at that pointer
        sw_write(32'h2000);
        run_insn(4'd0, 2'd3, 6'h20, 32'h300, 64'hA5A5_5A5A_0F0F_F0F0, 0, 0, 0, '0, 0);
        // R9: write wins over commit
        run_insn(4'd0, 2'd0, 6'd0, 32'h304, 64'h77, 0, 0, 1, 32'h0000_8000, 0);
        // R10: valid while busy is ignored
        run_insn(4'd0, 2'd1, 6'd0, 32'h308, 64'h1234, 1, 1, 0, '0, 1);
        model_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R8 watchdog expired: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule